// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank-State Monitor

This block watches the control pins of a DDR SDRAM bus: clock enable, chip select, the three strobe lines, the bank select and the address bus. It samples them on every rising clock edge and reports the decoded command on a one-hot output, one cycle later. It also gives the parameters that belong to that command: the bank, the row or column, the auto-precharge request, and for mode-register loads the target register and the op-code.

Alongside the decode it keeps an open/idle bit for each bank and a small tracker for the burst that is in flight. With these it can judge whether each command is legal. It flags misuse on a set of sticky violation bits, which stay set until a synchronous clear input is pulsed. The block only observes the bus and never drives it. It can sit beside a memory controller as a protocol checker, or in front of a memory model.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With chip select high the sampled command is reported as NOP (`cmd_oh` = 9'h001) whatever the other pins carry, and no bank state changes. Every output is registered: pins sampled at one edge show on the outputs after that edge. After reset, `cmd_oh` is 9'h001, all banks are idle and no violation is set.
- R2: With chip select low, {ras_n,cas_n,we_n} decodes as 111 NOP (bit 0), 011 ACTIVE (bit 1), 101 READ (bit 2), 100 WRITE (bit 3), 110 BURST STOP (bit 4), 010 PRECHARGE (bit 5), 001 refresh, and 000 MODE LOAD (bit 8). These are bit positions in `cmd_oh`, and exactly one bit is set each cycle.
- R3: ACTIVE opens the bank given on `ba` and reports that bank on `cmd_bank` and the row on `cmd_addr`. ACTIVE to a bank that is already open sets `viol[3]`.
- R4: READ and WRITE report the column on `cmd_addr` with address bit 10 cleared, and report address bit 10 on `cmd_ap`. The request does not persist from one access to the next. With `cmd_ap` set, the bank reads idle from the edge BURST_LEN/2 clocks after the access was sampled.
- R5: PRECHARGE with address bit 10 low closes only the bank on `ba`. With bit 10 high it closes every bank and `ba` is ignored.
- R6: BURST STOP is legal only within BURST_LEN/2 clocks after a READ without auto-precharge, and a legal BURST STOP ends that burst. After a WRITE, after a READ with auto-precharge, or when no burst is running, BURST STOP sets `viol[1]`.
- R7: The refresh encoding reports AUTO REFRESH (bit 6) when `cke` is high and SELF REFRESH entry (bit 7) when `cke` is low. For both, `cmd_bank`, `cmd_addr` and `cmd_ap` read 0.
- R8: MODE LOAD with `ba` = 00 targets the base register (`mr_ext` = 0), and with `ba` = 01 the extended register (`mr_ext` = 1). `mr_op` carries the address bus. `ba[1]` set is reserved: it sets `viol[0]` and is reported as NOP.
- R9: With `cke` low, any command other than NOP, DESELECT or refresh is illegal. It sets `viol[0]`, is reported as NOP and changes no bank state.
- R10: READ or WRITE to an idle bank sets `viol[2]`.
- R11: AUTO REFRESH or MODE LOAD while any bank is open sets `viol[4]`.
- R12: Violation bits are sticky. A cycle with `clr_viol` high clears all of them, and the clear wins over a violation detected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_viol | input | 1 | Synchronous clear of all violation bits |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Address bus |
| cmd_oh | output | 9 | One-hot decoded command |
| cmd_bank | output | BA_W | Bank of the command |
| cmd_addr | output | ADDR_W | Row or column of the command |
| cmd_ap | output | 1 | Auto-precharge requested by this access |
| mr_ext | output | 1 | Mode load targets the extended register |
| mr_op | output | ADDR_W | Mode load op-code |
| bank_open | output | 2**BA_W | Per-bank open flag |
| viol | output | 5 | Sticky violation flags |

## Verification
Some properties are checked by assertions on every cycle. A deselected bus always reads as NOP, and exactly one command bit is set. ACTIVE always leaves its bank open, and precharge-all leaves every bank idle. Violation bits never fall without a clear, an access to an idle bank is always flagged, and the burst counter stays in range. Other behaviour needs the bench's scenarios, because it depends on ordering over several cycles. Examples are the moment an auto-precharged bank closes, the window in which BURST STOP is legal, the auto-precharge flag not carrying over, refresh and mode-load decoding with pin values that must be ignored, and the clear winning over a same-cycle violation.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

   localparam int CMD_N  = 9;
   localparam int VIOL_N = 5;

   typedef enum logic [3:0] {
      C_NOP  = 4'd0,
      C_ACT  = 4'd1,
      C_RD   = 4'd2,
      C_WR   = 4'd3,
      C_BST  = 4'd4,
      C_PRE  = 4'd5,
      C_AREF = 4'd6,
      C_SREF = 4'd7,
      C_LMR  = 4'd8
   } cmd_e;

   localparam int V_RSV  = 0;
   localparam int V_BST  = 1;
   localparam int V_IDLE = 2;
   localparam int V_ACT  = 3;
   localparam int V_OPEN = 4;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
   import ddr_mon_pkg::*;
#(
   parameter int BA_W = 2
) (
   input  logic            cke,
   input  logic            cs_n,
   input  logic            ras_n,
   input  logic            cas_n,
   input  logic            we_n,
   input  logic [BA_W-1:1] ba_hi,
   output cmd_e            cmd,
   output logic            rsv
);

   always_comb begin
      cmd = C_NOP;
      rsv = 1'b0;
      if (!cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b111:  cmd = C_NOP;
            3'b011:  cmd = C_ACT;
            3'b101:  cmd = C_RD;
            3'b100:  cmd = C_WR;
            3'b110:  cmd = C_BST;
            3'b010:  cmd = C_PRE;
            3'b001:  cmd = cke ? C_AREF : C_SREF;
            default: cmd = C_LMR;
         endcase
      end
      if (!cke && cmd != C_NOP && cmd != C_SREF) begin
         rsv = 1'b1;
         cmd = C_NOP;
      end
      if (cmd == C_LMR && ba_hi != '0) begin
         rsv = 1'b1;
         cmd = C_NOP;
      end
   end

endmodule

// File: rtl/ddr_burst_tracker.sv
module ddr_burst_tracker #(
   parameter int BURST_LEN = 4,
   parameter int BA_W      = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            start_rd,
   input  logic            start_ap,
   input  logic [BA_W-1:0] start_bank,
   input  logic            bst_hit,
   output logic            rd_noap,
   output logic            ap_close,
   output logic [BA_W-1:0] ap_bank
);

   localparam int CLKS = BURST_LEN / 2;
   localparam int CW   = $clog2(CLKS + 1);

   if (BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
      $error("BURST_LEN must be 2, 4 or 8");
   end

   logic            active_q;
   logic            rd_q;
   logic            ap_q;
   logic [BA_W-1:0] bank_q;
   logic            ending;

   if (CLKS == 1) begin : g_single
      assign ending = active_q;
   end else begin : g_count
      logic [CW-1:0] rem_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     rem_q <= '0;
         else if (start)                 rem_q <= CW'(CLKS);
         else if (active_q && !ending)   rem_q <= rem_q - 1'b1;
      end
      assign ending = active_q && (rem_q == CW'(1));

      // R4
      burst_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
         active_q |-> (rem_q != '0 && rem_q <= CW'(CLKS)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rd_q     <= 1'b0;
         ap_q     <= 1'b0;
         bank_q   <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         rd_q     <= start_rd;
         ap_q     <= start_ap;
         bank_q   <= start_bank;
      end else if (bst_hit || ending) begin
         active_q <= 1'b0;
      end
   end

   assign rd_noap  = active_q && rd_q && !ap_q;
   assign ap_close = active_q && ap_q && (ending || start);
   assign ap_bank  = bank_q;

   // R6
   bst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bst_hit && !start) |=> !rd_noap);

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
   parameter int BA_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   open_en,
   input  logic [BA_W-1:0]        open_bank,
   input  logic                   pre_en,
   input  logic                   pre_all,
   input  logic [BA_W-1:0]        pre_bank,
   input  logic                   apc_en,
   input  logic [BA_W-1:0]        apc_bank,
   output logic [(1<<BA_W)-1:0]   bank_open
);

   localparam int NBANK = 1 << BA_W;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic open_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            open_q <= 1'b0;
         else if (open_en && open_bank == BA_W'(b))
            open_q <= 1'b1;
         else if ((pre_en && (pre_all || pre_bank == BA_W'(b))) ||
                  (apc_en && apc_bank == BA_W'(b)))
            open_q <= 1'b0;
      end
      assign bank_open[b] = open_q;
   end

   // R5
   pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_en && pre_all) |=> (bank_open == '0));

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
   import ddr_mon_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int BA_W      = 2,
   parameter int AP_BIT    = 10,
   parameter int BURST_LEN = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_viol,
   input  logic                  cke,
   input  logic                  cs_n,
   input  logic                  ras_n,
   input  logic                  cas_n,
   input  logic                  we_n,
   input  logic [BA_W-1:0]       ba,
   input  logic [ADDR_W-1:0]     addr,
   output logic [8:0]            cmd_oh,
   output logic [BA_W-1:0]       cmd_bank,
   output logic [ADDR_W-1:0]     cmd_addr,
   output logic                  cmd_ap,
   output logic                  mr_ext,
   output logic [ADDR_W-1:0]     mr_op,
   output logic [(1<<BA_W)-1:0]  bank_open,
   output logic [4:0]            viol
);

   localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

   if (BA_W < 2 || BA_W > 3) begin : g_bad_ba
      $error("BA_W must be 2 or 3");
   end
   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must lie inside the address bus");
   end

   cmd_e dcmd;
   logic drsv;

   ddr_cmd_decode #(.BA_W(BA_W)) u_dec (
      .cke   (cke),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .ba_hi (ba[BA_W-1:1]),
      .cmd   (dcmd),
      .rsv   (drsv)
   );

   logic is_act, is_rd, is_wr, is_bst, is_pre, is_aref, is_lmr;
   assign is_act  = (dcmd == C_ACT);
   assign is_rd   = (dcmd == C_RD);
   assign is_wr   = (dcmd == C_WR);
   assign is_bst  = (dcmd == C_BST);
   assign is_pre  = (dcmd == C_PRE);
   assign is_aref = (dcmd == C_AREF);
   assign is_lmr  = (dcmd == C_LMR);

   logic            rd_noap;
   logic            ap_close;
   logic [BA_W-1:0] ap_bank;

   ddr_burst_tracker #(.BURST_LEN(BURST_LEN), .BA_W(BA_W)) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (is_rd || is_wr),
      .start_rd   (is_rd),
      .start_ap   (addr[AP_BIT]),
      .start_bank (ba),
      .bst_hit    (is_bst && rd_noap),
      .rd_noap    (rd_noap),
      .ap_close   (ap_close),
      .ap_bank    (ap_bank)
   );

   ddr_bank_tracker #(.BA_W(BA_W)) u_banks (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_en   (is_act),
      .open_bank (ba),
      .pre_en    (is_pre),
      .pre_all   (addr[AP_BIT]),
      .pre_bank  (ba),
      .apc_en    (ap_close),
      .apc_bank  (ap_bank),
      .bank_open (bank_open)
   );

   logic              tgt_open;
   logic [VIOL_N-1:0] new_v;
   logic [BA_W-1:0]   bank_d;
   logic [ADDR_W-1:0] addr_d;
   logic              ap_d;

   assign tgt_open = bank_open[ba];

   always_comb begin
      new_v         = '0;
      new_v[V_RSV]  = drsv;
      new_v[V_BST]  = is_bst && !rd_noap;
      new_v[V_IDLE] = (is_rd || is_wr) && !tgt_open;
      new_v[V_ACT]  = is_act && tgt_open;
      new_v[V_OPEN] = (is_aref || is_lmr) && (|bank_open);

      bank_d = '0;
      addr_d = '0;
      ap_d   = 1'b0;
      unique case (dcmd)
         C_ACT: begin
            bank_d = ba;
            addr_d = addr;
         end
         C_RD, C_WR: begin
            bank_d = ba;
            addr_d = addr & ~AP_MASK;
            ap_d   = addr[AP_BIT];
         end
         C_PRE: begin
            bank_d = addr[AP_BIT] ? '0 : ba;
         end
         default: ;
      endcase
   end

   logic [VIOL_N-1:0] viol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_oh   <= 9'h001;
         cmd_bank <= '0;
         cmd_addr <= '0;
         cmd_ap   <= 1'b0;
         mr_ext   <= 1'b0;
         mr_op    <= '0;
         viol_q   <= '0;
      end else begin
         cmd_oh   <= CMD_N'(1) << dcmd;
         cmd_bank <= bank_d;
         cmd_addr <= addr_d;
         cmd_ap   <= ap_d;
         mr_ext   <= is_lmr ? ba[0] : 1'b0;
         mr_op    <= is_lmr ? addr : '0;
         viol_q   <= clr_viol ? '0 : (viol_q | new_v);
      end
   end

   assign viol = viol_q;

   // R1
   deselect_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (cmd_oh == 9'h001));

   // R2
   onehot_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cmd_oh) == 1);

   // R3
   act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |=> bank_open[$past(ba)]);

   // R10
   idle_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((is_rd || is_wr) && !tgt_open && !clr_viol) |=> viol_q[V_IDLE]);

   // R12
   viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(viol_q) & ~viol_q)) |-> $past(clr_viol));

endmodule

// File: tb/sim_ddr_cmd_monitor.sv
`timescale 1ns/1ps
module sim_ddr_cmd_monitor;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr_viol = 1'b0;
   logic        cke = 1'b1;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic [8:0]  cmd_oh;
   logic [1:0]  cmd_bank;
   logic [12:0] cmd_addr;
   logic        cmd_ap, mr_ext;
   logic [12:0] mr_op;
   logic [3:0]  bank_open;
   logic [4:0]  viol;

   always #5 clk = ~clk;

   ddr_cmd_monitor u0 (
      .clk(clk), .rst_n(rst_n), .clr_viol(clr_viol), .cke(cke),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .addr(addr), .cmd_oh(cmd_oh), .cmd_bank(cmd_bank),
      .cmd_addr(cmd_addr), .cmd_ap(cmd_ap), .mr_ext(mr_ext),
      .mr_op(mr_op), .bank_open(bank_open), .viol(viol)
   );

   typedef struct packed {
      logic [8:0]  oh;
      logic [3:0]  bo;
      logic [4:0]  v;
      logic        cf;
      logic [1:0]  bk;
      logic [12:0] ad;
      logic        ap;
      logic        mx;
      logic [12:0] op;
   } exp_t;

   exp_t  expq[$];
   string tagq[$];
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   // {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] K_DES = 4'b1000, K_NOP = 4'b0111, K_ACT = 4'b0011,
                          K_RD  = 4'b0101, K_WR  = 4'b0100, K_BST = 4'b0110,
                          K_PRE = 4'b0010, K_REF = 4'b0001, K_LMR = 4'b0000;
   localparam logic [8:0] O_NOP = 9'h001, O_ACT = 9'h002, O_RD = 9'h004,
                          O_WR = 9'h008, O_BST = 9'h010, O_PRE = 9'h020,
                          O_AREF = 9'h040, O_SREF = 9'h080, O_LMR = 9'h100;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic issue_x(input logic [3:0] k, input logic ke, input logic [1:0] b,
                          input logic [12:0] a, input logic clr,
                          input logic [8:0] oh, input logic [3:0] bo, input logic [4:0] v,
                          input logic cf, input logic [1:0] bk, input logic [12:0] ad,
                          input logic ap, input logic mx, input logic [12:0] op,
                          input string tag);
      exp_t e;
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = k;
      cke = ke; ba = b; addr = a; clr_viol = clr;
      e.oh = oh; e.bo = bo; e.v = v; e.cf = cf;
      e.bk = bk; e.ad = ad; e.ap = ap; e.mx = mx; e.op = op;
      expq.push_back(e);
      tagq.push_back(tag);
   endtask

   task automatic issue(input logic [3:0] k, input logic ke, input logic [1:0] b,
                        input logic [12:0] a, input logic clr,
                        input logic [8:0] oh, input logic [3:0] bo, input logic [4:0] v,
                        input string tag);
      issue_x(k, ke, b, a, clr, oh, bo, v, 1'b0, '0, '0, 1'b0, 1'b0, '0, tag);
   endtask

   // monitor: compares the outputs after each edge against the queued item
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (expq.size() > 0) begin
            exp_t e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(cmd_oh == e.oh, t, "cmd_oh", int'(cmd_oh), int'(e.oh));
            check(bank_open == e.bo, t, "bank_open", int'(bank_open), int'(e.bo));
            check(viol == e.v, t, "viol", int'(viol), int'(e.v));
            if (e.cf) begin
               check(cmd_bank == e.bk, t, "cmd_bank", int'(cmd_bank), int'(e.bk));
               check(cmd_addr == e.ad, t, "cmd_addr", int'(cmd_addr), int'(e.ad));
               check(cmd_ap == e.ap, t, "cmd_ap", int'(cmd_ap), int'(e.ap));
               check(mr_ext == e.mx, t, "mr_ext", int'(mr_ext), int'(e.mx));
               check(mr_op == e.op, t, "mr_op", int'(mr_op), int'(e.op));
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cmd_oh == O_NOP, "R1 reset", "cmd_oh", int'(cmd_oh), int'(O_NOP));
      check(bank_open == 4'h0, "R1 reset", "bank_open", int'(bank_open), 0);
      check(viol == 5'h00, "R1 reset", "viol", int'(viol), 0);

      // R1 deselect with noisy pins
      issue(K_DES, 1'b1, 2'd2, 13'h1ABC, 1'b0, O_NOP, 4'h0, 5'h00, "R1 deselect");
      issue(K_NOP, 1'b1, 2'd0, 13'h0000, 1'b0, O_NOP, 4'h0, 5'h00, "R2 nop");
      // R3 activate
      issue_x(K_ACT, 1'b1, 2'd1, 13'h0123, 1'b0, O_ACT, 4'h2, 5'h00,
              1'b1, 2'd1, 13'h0123, 1'b0, 1'b0, 13'h0, "R3 activate");
      issue(K_ACT, 1'b1, 2'd1, 13'h0055, 1'b0, O_ACT, 4'h2, 5'h08, "R3 act open bank");
      issue(K_NOP, 1'b1, 2'd0, 13'h0000, 1'b1, O_NOP, 4'h2, 5'h00, "R12 clear");
      // R4 read no auto-precharge, then legal stop
      issue_x(K_RD, 1'b1, 2'd1, 13'h0045, 1'b0, O_RD, 4'h2, 5'h00,
              1'b1, 2'd1, 13'h0045, 1'b0, 1'b0, 13'h0, "R4 read");
      issue(K_BST, 1'b1, 2'd0, 13'h0000, 1'b0, O_BST, 4'h2, 5'h00, "R6 legal stop");
      issue(K_BST, 1'b1, 2'd0, 13'h0000, 1'b0, O_BST, 4'h2, 5'h02, "R6 stop no burst");
      issue(K_NOP, 1'b1, 2'd0, 13'h0000, 1'b1, O_NOP, 4'h2, 5'h00, "R12 clear");
      // R4 write with auto-precharge, stop during write, bank closes at k+2
      issue_x(K_WR, 1'b1, 2'd1, 13'h0420, 1'b0, O_WR, 4'h2, 5'h00,
              1'b1, 2'd1, 13'h0020, 1'b1, 1'b0, 13'h0, "R4 write ap");
      issue(K_BST, 1'b1, 2'd0, 13'h0000, 1'b0, O_BST, 4'h2, 5'h02, "R6 stop in write");
      issue(K_NOP, 1'b1, 2'd0, 13'h0000, 1'b0, O_NOP, 4'h0, 5'h02, "R4 ap close");
      issue(K_NOP, 1'b1, 2'd0, 13'h0000, 1'b1, O_NOP, 4'h0, 5'h00, "R12 clear");
      // R10 read to idle bank
      issue(K_RD, 1'b1, 2'd1, 13'h0010, 1'b0, O_RD, 4'h0, 5'h04, "R10 idle read");
      issue(K_NOP, 1'b1, 2'd0, 13'h0000, 1'b1, O_NOP, 4'h0, 5'h00, "R12 clear");
      issue(K_ACT, 1'b1, 2'd0, 13'h0005, 1'b0, O_ACT, 4'h1, 5'h00, "R3 act b0");
      issue(K_ACT, 1'b1, 2'd2, 13'h0007, 1'b0, O_ACT, 4'h5, 5'h00, "R3 act b2");
      // R4 flag does not persist
      issue_x(K_RD, 1'b1, 2'd2, 13'h0008, 1'b0, O_RD, 4'h5, 5'h00,
              1'b1, 2'd2, 13'h0008, 1'b0, 1'b0, 13'h0, "R4 nonpersistent");
      issue(K_NOP, 1'b1, 2'd0, 13'h0000, 1'b0, O_NOP, 4'h5, 5'h00, "R4 bank stays");
      issue(K_NOP, 1'b1, 2'd0, 13'h0000, 1'b0, O_NOP, 4'h5, 5'h00, "R4 bank stays");
      // R11 refresh while open
      issue(K_REF, 1'b1, 2'd0, 13'h0000, 1'b0, O_AREF, 4'h5, 5'h10, "R11 refresh open");
      issue(K_NOP, 1'b1, 2'd0, 13'h0000, 1'b1, O_NOP, 4'h5, 5'h00, "R12 clear");
      // R5 precharge single and all
      issue(K_PRE, 1'b1, 2'd0, 13'h0000, 1'b0, O_PRE, 4'h4, 5'h00, "R5 pre single");
      issue(K_ACT, 1'b1, 2'd0, 13'h0009, 1'b0, O_ACT, 4'h5, 5'h00, "R3 reopen");
      issue(K_PRE, 1'b1, 2'd3, 13'h0400, 1'b0, O_PRE, 4'h0, 5'h00, "R5 pre all");
      // R7 refresh ignores bank and address
      issue_x(K_REF, 1'b1, 2'd2, 13'h1FFF, 1'b0, O_AREF, 4'h0, 5'h00,
              1'b1, 2'd0, 13'h0000, 1'b0, 1'b0, 13'h0, "R7 auto refresh");
      // R8 mode loads
      issue_x(K_LMR, 1'b1, 2'd0, 13'h0031, 1'b0, O_LMR, 4'h0, 5'h00,
              1'b1, 2'd0, 13'h0000, 1'b0, 1'b0, 13'h0031, "R8 base mode");
      issue_x(K_LMR, 1'b1, 2'd1, 13'h0002, 1'b0, O_LMR, 4'h0, 5'h00,
              1'b1, 2'd0, 13'h0000, 1'b0, 1'b1, 13'h0002, "R8 ext mode");
      issue(K_LMR, 1'b1, 2'd2, 13'h0002, 1'b0, O_NOP, 4'h0, 5'h01, "R8 reserved");
      // R12 clear beats a same-cycle violation
      issue(K_LMR, 1'b1, 2'd3, 13'h0002, 1'b1, O_NOP, 4'h0, 5'h00, "R12 clear priority");
      // R7 self refresh entry
      issue_x(K_REF, 1'b0, 2'd1, 13'h0ABC, 1'b0, O_SREF, 4'h0, 5'h00,
              1'b1, 2'd0, 13'h0000, 1'b0, 1'b0, 13'h0, "R7 self refresh");
      // R9 command with clock enable low
      issue(K_ACT, 1'b0, 2'd0, 13'h0003, 1'b0, O_NOP, 4'h0, 5'h01, "R9 cke low act");
      issue(K_NOP, 1'b1, 2'd0, 13'h0000, 1'b1, O_NOP, 4'h0, 5'h00, "R12 clear");
      issue(K_ACT, 1'b1, 2'd3, 13'h0011, 1'b0, O_ACT, 4'h8, 5'h00, "R3 act b3");
      issue(K_LMR, 1'b1, 2'd0, 13'h0021, 1'b0, O_LMR, 4'h8, 5'h10, "R11 mode load open");
      issue_x(K_WR, 1'b1, 2'd3, 13'h0004, 1'b0, O_WR, 4'h8, 5'h10,
              1'b1, 2'd3, 13'h0004, 1'b0, 1'b0, 13'h0, "R2 write");
      issue(K_NOP, 1'b1, 2'd0, 13'h0000, 1'b0, O_NOP, 4'h8, 5'h10, "R2 nop");

      repeat (4) @(posedge clk);
      #3;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule